// File: doc/BRIEF.md
# Zero-Page Multiply and Divide Unit

This block is the sequential arithmetic engine behind an 8-bit core's accumulator multiply and divide operations. When started, it reads its operand bytes from a memory port through zero-page addresses formed from a base byte plus the X index. It then iterates one bit per cycle and writes one result byte onto the stack. The other result byte and the decremented stack pointer come back on dedicated outputs. The core drives its register values in and takes the results when the done pulse appears.

A multiply forms the 16-bit product of the accumulator and one zero-page byte. The low half becomes the new accumulator and the high half is pushed. A divide reads a 16-bit dividend from two consecutive zero-page bytes and divides it by the accumulator. The quotient becomes the new accumulator and the bitwise inverse of the remainder is pushed. A zero divisor aborts the divide early and the block reports it. A quotient that does not fit in one byte is flagged.

The memory port is byte wide with an asynchronous read: the read data must answer the address in the same cycle. Writes take effect on the clock edge that ends a cycle with the write enable high.

Top module: `zp_muldiv`

## Requirements
- R1: While reset is held and after it is released with no start, done, divide-by-zero, overflow and write enable are low, and the accumulator and stack pointer result outputs read 0.
- R2: With operation select 0 (multiply), the product of the accumulator and the byte read at zero-page address (base + X) mod 256 is formed. Its low byte appears on the accumulator output and its high byte is written to the stack. The stack pointer output equals S − 1 mod 256.
- R3: With operation select 1 (divide), the dividend low byte is read at (base + X) mod 256 and the high byte at (base + X + 1) mod 256, both in page 0x00. The accumulator output is the quotient modulo 256, and the bitwise inverse of the remainder is written to the stack. The stack pointer output equals S − 1 mod 256.
- R4: The overflow output is high together with done exactly when a divide has a nonzero divisor that is not greater than the dividend's high byte. It is low for every multiply.
- R5: A divide with accumulator 0 performs no memory write. It raises the divide-by-zero output with done, returns the accumulator and S unchanged, and signals done on the 2nd rising edge after the edge that accepts the start.
- R6: The stack write address is S in bits 7:0 and the page-select input in bit 8, with bits 15:9 zero. Every operand input, including the page select, is captured on the edge that accepts the start.
- R7: Each completed multiply or divide with a nonzero divisor performs exactly one memory write. Done is high for exactly one cycle, namely the cycle right after the write cycle.
- R8: Done is first high after the 10th rising edge following the accepting edge for a multiply, and after the 19th for a divide.
- R9: A start raised while an operation is in progress is ignored: the running operation's results are unchanged and no further done or write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_div_i | input | 1 | 0 = multiply, 1 = divide |
| stk_page_i | input | 1 | Stack page select (bit 8 of the stack address) |
| acc_i | input | 8 | Accumulator value |
| idx_i | input | 8 | X index value |
| sp_i | input | 8 | Stack pointer value |
| zp_base_i | input | 8 | Zero-page base byte |
| mem_rdata_i | input | 8 | Memory read data for the current address |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| acc_o | output | 8 | Result accumulator value |
| sp_o | output | 8 | Result stack pointer value |
| done_o | output | 1 | One-cycle completion pulse |
| divzero_o | output | 1 | Divide by zero, valid with done |
| ovf_o | output | 1 | Quotient overflow, valid with done |

## Verification
A corrupted step counter or state register shows up as done arriving on the wrong edge, which the latency check catches within twenty cycles of the start. A wrong shift or carry in either iteration register changes the pushed byte and the accumulator output at the same done pulse. Operand sets with carries across every bit, wrapped zero-page pointers and a maximal dividend high byte make sure such a fault reaches the ports. A broken idle guard yields a second write or a second done pulse within the quiet window that follows each operation.

// File: rtl/zmd_pkg.sv
package zmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDL,
    ST_RDH,
    ST_MUL,
    ST_DIV,
    ST_WR,
    ST_FIN
  } zmd_state_e;
endpackage

// File: rtl/zmd_fsm.sv
module zmd_fsm
  import zmd_pkg::*;
#(
  parameter int MUL_STEPS = 8,
  parameter int DIV_STEPS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       is_div_i,
  input  logic       dvs_zero_i,
  output zmd_state_e state_o,
  output logic       mul_load_o,
  output logic       div_load_o,
  output logic       mul_step_o,
  output logic       div_step_o
);
  localparam int CW = $clog2(DIV_STEPS + 1);

  zmd_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RDL;
      ST_RDL: begin
        cnt_d   = '0;
        state_d = is_div_i ? ST_RDH : ST_MUL;
      end
      ST_RDH: begin
        cnt_d   = '0;
        state_d = dvs_zero_i ? ST_FIN : ST_DIV;
      end
      ST_MUL: begin
        if (cnt_q == CW'(MUL_STEPS - 1)) state_d = ST_WR;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_DIV: begin
        if (cnt_q == CW'(DIV_STEPS - 1)) state_d = ST_WR;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_WR:   state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o    = state_q;
  assign mul_load_o = (state_q == ST_RDL) && !is_div_i;
  assign div_load_o = (state_q == ST_RDH) && !dvs_zero_i;
  assign mul_step_o = (state_q == ST_MUL);
  assign div_step_o = (state_q == ST_DIV);

  // R9: a fetch state is only ever entered from idle
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_RDL));
endmodule

// File: rtl/zmd_mul_core.sv
module zmd_mul_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] prod_q, prod_d;
  logic [W-1:0]   mcand_q, mcand_d;
  logic [W:0]     sum;

  always_comb begin
    sum     = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
    prod_d  = prod_q;
    mcand_d = mcand_q;
    if (load_i) begin
      prod_d  = {{W{1'b0}}, mplier_i};
      mcand_d = mcand_i;
    end else if (step_i) begin
      prod_d  = {sum, prod_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      mcand_q <= '0;
    end else begin
      prod_q  <= prod_d;
      mcand_q <= mcand_d;
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/zmd_div_core.sv
module zmd_div_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] quo_o,
  output logic [W-1:0]   rem_o
);
  logic [2*W-1:0] quo_q, quo_d;
  logic [W-1:0]   rem_q, rem_d, dvs_q, dvs_d;
  logic [W:0]     trial, diff;
  logic           fits;

  always_comb begin
    trial = {rem_q, quo_q[2*W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
    quo_d = quo_q;
    rem_d = rem_q;
    dvs_d = dvs_q;
    if (load_i) begin
      quo_d = dvd_i;
      rem_d = '0;
      dvs_d = dvs_i;
    end else if (step_i) begin
      quo_d = {quo_q[2*W-2:0], fits};
      rem_d = fits ? diff[W-1:0] : trial[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // R3: partial remainder stays below the divisor after every step
  a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (rem_q < dvs_q));
endmodule

// File: rtl/zp_muldiv.sv
module zp_muldiv
  import zmd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           op_div_i,
  input  logic           stk_page_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   idx_i,
  input  logic [W-1:0]   sp_i,
  input  logic [W-1:0]   zp_base_i,
  input  logic [W-1:0]   mem_rdata_i,
  output logic [2*W-1:0] mem_addr_o,
  output logic [W-1:0]   mem_wdata_o,
  output logic           mem_we_o,
  output logic [W-1:0]   acc_o,
  output logic [W-1:0]   sp_o,
  output logic           done_o,
  output logic           divzero_o,
  output logic           ovf_o
);
  localparam int AW = 2 * W;

  zmd_state_e     state;
  logic           mul_load, div_load, mul_step, div_step;
  logic           accept;
  logic           op_q, page_q, dz_q, ovf_q;
  logic [W-1:0]   a_q, ptr_q, s_q, lo_q, acc_q, sp_q;
  logic [AW-1:0]  prod, quo;
  logic [W-1:0]   rem;

  assign accept = (state == ST_IDLE) && start_i;

  zmd_fsm #(.MUL_STEPS(W), .DIV_STEPS(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_div_i(op_q),
    .dvs_zero_i(a_q == '0), .state_o(state), .mul_load_o(mul_load),
    .div_load_o(div_load), .mul_step_o(mul_step), .div_step_o(div_step)
  );

  zmd_mul_core #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load_i(mul_load), .step_i(mul_step),
    .mcand_i(a_q), .mplier_i(mem_rdata_i), .prod_o(prod)
  );

  zmd_div_core #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .load_i(div_load), .step_i(div_step),
    .dvd_i({mem_rdata_i, lo_q}), .dvs_i(a_q), .quo_o(quo), .rem_o(rem)
  );

  // operand capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= 1'b0; page_q <= 1'b0;
      a_q <= '0; ptr_q <= '0; s_q <= '0; lo_q <= '0;
    end else begin
      if (accept) begin
        op_q   <= op_div_i;
        page_q <= stk_page_i;
        a_q    <= acc_i;
        ptr_q  <= zp_base_i + idx_i;
        s_q    <= sp_i;
      end
      if (state == ST_RDL) lo_q <= mem_rdata_i;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; sp_q <= '0; dz_q <= 1'b0; ovf_q <= 1'b0;
    end else if (state == ST_WR) begin
      acc_q <= op_q ? quo[W-1:0] : prod[W-1:0];
      sp_q  <= s_q - 1'b1;
      dz_q  <= 1'b0;
      ovf_q <= op_q && (quo[AW-1:W] != '0);
    end else if ((state == ST_RDH) && (a_q == '0)) begin
      acc_q <= a_q;
      sp_q  <= s_q;
      dz_q  <= 1'b1;
      ovf_q <= 1'b0;
    end
  end

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    unique case (state)
      ST_RDL: mem_addr_o = {{W{1'b0}}, ptr_q};
      ST_RDH: mem_addr_o = {{W{1'b0}}, ptr_q + 1'b1};
      ST_WR: begin
        mem_addr_o  = {{(W-1){1'b0}}, page_q, s_q};
        mem_wdata_o = op_q ? ~rem : prod[AW-1:W];
        mem_we_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign done_o    = (state == ST_FIN);
  assign divzero_o = done_o && dz_q;
  assign ovf_o     = done_o && ovf_q;
  assign acc_o     = acc_q;
  assign sp_o      = sp_q;

  // R7: the stack write is followed by a single-cycle done
  a_r7_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> done_o);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: no write precedes a divide-by-zero completion
  a_r5_no_write_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    divzero_o |-> !$past(mem_we_o));
  // R6: stack writes stay in page 0x00 or 0x01
  a_r6_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o[AW-1:W+1] == '0));
  // R4: overflow only accompanies a real divide completion
  a_r4_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (done_o && !divzero_o));
endmodule

// File: tb/sim_zp_muldiv.sv
`timescale 1ns/1ps
module sim_zp_muldiv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_div = 1'b0, page = 1'b0;
  logic [7:0] acc = '0, idx = '0, sp = '0, zp = '0;
  logic [7:0] rdata, wdata, acc_out, sp_out;
  logic [15:0] addr;
  logic we, done, dz, ovf;

  logic [7:0] mem [0:511];
  int checks = 0, errors = 0, wr_cnt = 0, lat = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign rdata = mem[addr[8:0]];

  always @(negedge clk) if (we) begin
    mem[addr[8:0]] = wdata;
    wr_cnt++;
  end

  zp_muldiv u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_div_i(op_div),
    .stk_page_i(page), .acc_i(acc), .idx_i(idx), .sp_i(sp),
    .zp_base_i(zp), .mem_rdata_i(rdata), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_we_o(we), .acc_o(acc_out), .sp_o(sp_out),
    .done_o(done), .divzero_o(dz), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one operation; optionally poke a second start while busy
  task automatic run_op(input bit d, input logic [7:0] a, x, z, s, input bit pg, input bit poke);
    wr_cnt = 0;
    @(negedge clk);
    op_div = d; acc = a; idx = x; zp = z; sp = s; page = pg; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk); #1;
      lat++;
      if (poke && lat == 3) begin
        start = 1'b1; op_div = ~d; acc = 8'h01; sp = 8'h33; page = ~pg;
      end
      if (poke && lat == 4) start = 1'b0;
    end
  endtask

  task automatic after_done(input string req);
    @(posedge clk); #1;
    chk(done == 1'b0, req, done, 0);
  endtask

  task automatic t_reset;
    chk(done == 0 && dz == 0 && ovf == 0 && we == 0, "R1", {done, dz, ovf, we}, 0);
    chk(acc_out == 0 && sp_out == 0, "R1", {acc_out, sp_out}, 0);
  endtask

  task automatic t_mul(input logic [7:0] a, x, z, s, m, input bit pg, input bit poke);
    logic [15:0] p;
    logic [7:0]  ptr;
    ptr = z + x;
    mem[{1'b0, ptr}] = m;
    p = a * m;
    run_op(1'b0, a, x, z, s, pg, poke);
    chk(lat == 10, "R8 mul latency", lat, 10);
    chk(acc_out == p[7:0], "R2 low byte", acc_out, p[7:0]);
    chk(sp_out == 8'(s - 1), "R2 stack pointer", sp_out, 8'(s - 1));
    chk(dz == 0 && ovf == 0, "R4 flags on multiply", {dz, ovf}, 0);
    chk(wr_cnt == 1, "R7 one write", wr_cnt, 1);
    chk(mem[{pg, s}] == p[15:8], "R2 R6 pushed high byte", mem[{pg, s}], p[15:8]);
    after_done("R7 done width");
  endtask

  task automatic t_div(input logic [7:0] a, x, z, s, lo, hi, input bit pg);
    logic [15:0] n, q;
    logic [7:0]  r, ptr;
    ptr = z + x;
    mem[{1'b0, ptr}] = lo;
    mem[{1'b0, 8'(ptr + 1)}] = hi;
    n = {hi, lo};
    q = n / a;
    r = 8'(n % a);
    run_op(1'b1, a, x, z, s, pg, 1'b0);
    chk(lat == 19, "R8 div latency", lat, 19);
    chk(acc_out == q[7:0], "R3 quotient", acc_out, q[7:0]);
    chk(mem[{pg, s}] == ~r, "R3 R6 inverted remainder", mem[{pg, s}], ~r);
    chk(sp_out == 8'(s - 1), "R3 stack pointer", sp_out, 8'(s - 1));
    chk(ovf == (hi >= a), "R4 overflow", ovf, (hi >= a));
    chk(dz == 0 && wr_cnt == 1, "R7 one write", wr_cnt, 1);
    after_done("R7 done width");
  endtask

  task automatic t_divzero;
    mem[{1'b1, 8'h44}] = 8'h5A;
    mem[8'h21] = 8'h10; mem[8'h22] = 8'h02;
    run_op(1'b1, 8'h00, 8'h01, 8'h20, 8'h44, 1'b1, 1'b0);
    chk(lat == 2, "R5 latency", lat, 2);
    chk(dz == 1 && ovf == 0, "R5 flag", {dz, ovf}, 2);
    chk(acc_out == 8'h00 && sp_out == 8'h44, "R5 registers kept", {acc_out, sp_out}, 16'h0044);
    chk(wr_cnt == 0 && mem[{1'b1, 8'h44}] == 8'h5A, "R5 no write", wr_cnt, 0);
    after_done("R7 done width");
  endtask

  task automatic t_busy_start;
    t_mul(8'hB5, 8'h02, 8'h60, 8'h90, 8'h6B, 1'b0, 1'b1);
    for (int i = 0; i < 25; i++) begin
      @(posedge clk); #1;
      chk(done == 0 && wr_cnt == 1, "R9 no extra done or write", {done, 8'(wr_cnt)}, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    #10;
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    t_reset;
    t_mul(8'h9C, 8'h05, 8'h40, 8'h80, 8'hE7, 1'b1, 1'b0);
    t_mul(8'hFF, 8'h10, 8'hF8, 8'h00, 8'hFF, 1'b0, 1'b0);   // R2 pointer wrap, S wrap
    t_mul(8'h37, 8'h00, 8'h12, 8'hA0, 8'h00, 1'b1, 1'b0);
    t_div(8'h3D, 8'h04, 8'h30, 8'h50, 8'hBC, 8'h0A, 1'b1);
    t_div(8'hF1, 8'h0F, 8'hF0, 8'hC0, 8'h99, 8'hF0, 1'b0);  // R3 high byte wraps to 0x00
    t_div(8'h12, 8'h00, 8'h70, 8'h81, 8'h34, 8'h12, 1'b0);  // R4 overflow
    t_div(8'h01, 8'h00, 8'h74, 8'h82, 8'hFF, 8'hFF, 1'b1);  // R4 maximal overflow
    t_divzero;
    t_busy_start;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule